// File: doc/BRIEF.md
# Balanced Nine-Bit Lane Encoder

This block is the transmit-side encoder of a three-lane serial link that moves a 21-bit parallel word per word period. The word is cut into three seven-bit groups, one per lane. In the balanced mode each group is either sent as it is or sent complemented, whichever keeps that lane's running digital sum closer to zero. Two complementary flag bits go out ahead of the group so that the far end can undo the inversion. A fourth serial output carries the link clock pattern, and that pattern is itself kept DC balanced by alternating its high time between four and five bit slots of nine. A raw mode sends the bare seven data bits per lane, with no flags and no inversion.

The user pulses `word_stb` with a new word. The block then shifts one bit per `bit_en` pulse on every lane at once: nine pulses per word in balanced mode, seven in raw mode. The mode is sampled with the word, so successive words may use different modes.

Top module: `dcb_lane_encoder`

## Requirements
- R1: Lane i carries word bits [7i+6 : 7i]. Lane 0 takes bits 6..0, lane 1 takes bits 13..7 and lane 2 takes bits 20..14.
- R2: The first bit of a word appears on the outputs in the cycle after `word_stb` is sampled. Each sampled `bit_en` advances to the next bit. When neither `word_stb` nor `bit_en` is sampled, the outputs hold.
- R3: In balanced mode a symbol is DCA, then DCB, then the data bits from most significant to least significant. DCA=1, DCB=0 marks a complemented group, and DCA=0, DCB=1 marks a group sent unchanged.
- R4: The disparity of a group is (ones − zeros) of its seven bits, and the flags add nothing to it. A lane complements its group exactly when its running sum is nonzero and has the same sign as that disparity. The disparity of the symbol actually sent is then added to the running sum, and the sum changes at no other time.
- R5: Every lane's running sum stays within ±7 at all times.
- R6: In balanced mode the clock lane sends 4 ones then 5 zeros for one word and 5 ones then 4 zeros for the next, alternating. It starts with the 4-ones pattern after reset.
- R7: In raw mode each lane sends its 7 data bits most significant first, with no flags and no inversion. Raw words leave the running sums unchanged and leave the clock-lane phase unchanged.
- R8: In raw mode the clock lane sends 4 ones then 3 zeros.
- R9: A synchronous reset drives all serial outputs to 0, clears every running sum and selects the 4/9 clock phase.
- R10: When `word_stb` and `bit_en` are sampled together, the new word is loaded and no shift takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bal_en | input | 1 | 1 selects balanced 9-bit symbols, 0 selects raw 7-bit symbols; sampled with `word_stb` |
| word_stb | input | 1 | Loads `word_in` and starts a new symbol on every lane |
| word_in | input | 21 | Parallel word |
| bit_en | input | 1 | Advances all serial outputs by one bit |
| lane_out | output | 3 | Serial data, one bit per lane |
| clk_lane_out | output | 1 | Serial clock-lane pattern |

## Verification
The assertions check on every cycle that the running sums stay in bound and change only on a balanced load. They also check that the outputs hold when nothing is sampled, that the two flag bits are complementary, that a balanced clock symbol starts high, and that reset clears the state. Only the bench scenarios can show the inversion choice, the bit order and lane mapping, the alternation of the clock high time, and the way raw words leave the balance state alone. The bench shows these by comparing each serial bit against a reference model over directed words (all zeros, all ones, mixed modes) and over seeded random words with random gaps between bit enables.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

   typedef enum logic {
      PH_SHORT = 1'b0,   // clock high for SYM_W/2 slots
      PH_LONG  = 1'b1    // clock high for SYM_W/2+1 slots
   } clk_phase_e;

   // signed disparity of a group of gw bits holding "ones" ones
   function automatic int group_disp(input int ones, input int gw);
      return 2 * ones - gw;
   endfunction

endpackage

// File: rtl/dcb_lane_slice.sv
module dcb_lane_slice #(
   parameter int GROUP_W = 7,
   parameter int DSUM_W  = 5
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      bal_en,
   input  logic                      load,
   input  logic                      shift,
   input  logic [GROUP_W-1:0]        grp,
   output logic                      ser,
   output logic signed [DSUM_W-1:0]  run_sum
);
   import dcb_pkg::*;

   localparam int SYM_W = GROUP_W + 2;
   localparam int CNT_W = $clog2(GROUP_W + 1);

   logic [CNT_W-1:0]         ones;
   logic signed [DSUM_W-1:0] disp;
   logic signed [DSUM_W-1:0] tx_disp;
   logic signed [DSUM_W-1:0] rs_q;
   logic                     do_inv;
   logic [SYM_W-1:0]         sym_d;
   logic [SYM_W-1:0]         sr_q;

   always_comb begin
      ones    = CNT_W'($countones(grp));
      disp    = DSUM_W'(group_disp(int'(ones), GROUP_W));
      // same nonzero sign as the running sum -> complement
      do_inv  = bal_en && (rs_q != '0) && (disp[DSUM_W-1] == rs_q[DSUM_W-1]);
      tx_disp = do_inv ? -disp : disp;
      if (bal_en)
         sym_d = {do_inv, ~do_inv, (do_inv ? ~grp : grp)};
      else
         sym_d = {grp, 2'b00};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sr_q <= '0;
         rs_q <= '0;
      end else if (load) begin
         sr_q <= sym_d;
         if (bal_en)
            rs_q <= rs_q + tx_disp;
      end else if (shift) begin
         sr_q <= {sr_q[SYM_W-2:0], 1'b0};
      end
   end

   assign ser     = sr_q[SYM_W-1];
   assign run_sum = rs_q;

endmodule

// File: rtl/dcb_clk_lane.sv
module dcb_clk_lane #(
   parameter int GROUP_W = 7
) (
   input  logic clk,
   input  logic rst,
   input  logic bal_en,
   input  logic load,
   input  logic shift,
   output logic ser
);
   import dcb_pkg::*;

   localparam int SYM_W   = GROUP_W + 2;
   localparam int HI_SHRT = SYM_W / 2;
   localparam int HI_LONG = SYM_W / 2 + 1;
   localparam int HI_RAW  = (GROUP_W + 1) / 2;

   function automatic logic [SYM_W-1:0] top_ones(input int h);
      logic [SYM_W-1:0] m;
      for (int i = 0; i < SYM_W; i++)
         m[SYM_W-1-i] = (i < h);
      return m;
   endfunction

   localparam logic [SYM_W-1:0] PAT_SHRT = top_ones(HI_SHRT);
   localparam logic [SYM_W-1:0] PAT_LONG = top_ones(HI_LONG);
   localparam logic [SYM_W-1:0] PAT_RAW  = top_ones(HI_RAW);

   clk_phase_e       phase_q;
   logic [SYM_W-1:0] sr_q;
   logic [SYM_W-1:0] pat_d;

   always_comb begin
      if (!bal_en)
         pat_d = PAT_RAW;
      else if (phase_q == PH_LONG)
         pat_d = PAT_LONG;
      else
         pat_d = PAT_SHRT;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_SHORT;
         sr_q    <= '0;
      end else if (load) begin
         sr_q <= pat_d;
         if (bal_en)
            phase_q <= (phase_q == PH_LONG) ? PH_SHORT : PH_LONG;
      end else if (shift) begin
         sr_q <= {sr_q[SYM_W-2:0], 1'b0};
      end
   end

   assign ser = sr_q[SYM_W-1];

endmodule

// File: rtl/dcb_lane_encoder.sv
module dcb_lane_encoder #(
   parameter int LANES   = 3,
   parameter int GROUP_W = 7,
   parameter int DSUM_W  = 5
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       bal_en,
   input  logic                       word_stb,
   input  logic [LANES*GROUP_W-1:0]   word_in,
   input  logic                       bit_en,
   output logic [LANES-1:0]           lane_out,
   output logic                       clk_lane_out
);
   localparam int WORD_W  = LANES * GROUP_W;
   localparam int MIN_DSW = $clog2(GROUP_W + 1) + 2;

   if (LANES < 1) begin : g_bad_lanes
      $error("dcb_lane_encoder: LANES must be at least 1");
   end
   if (GROUP_W < 2) begin : g_bad_group
      $error("dcb_lane_encoder: GROUP_W must be at least 2");
   end
   if (DSUM_W < MIN_DSW) begin : g_bad_dsum
      $error("dcb_lane_encoder: DSUM_W too narrow for a +-GROUP_W running sum");
   end

   logic                       shift;
   logic [LANES*DSUM_W-1:0]    run_sums;
   logic [WORD_W-1:0]          word_w;

   assign word_w = word_in;
   assign shift  = bit_en && !word_stb;   // a load wins over a shift

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic signed [DSUM_W-1:0] rs_l;
      dcb_lane_slice #(
         .GROUP_W (GROUP_W),
         .DSUM_W  (DSUM_W)
      ) u_slice (
         .clk     (clk),
         .rst     (rst),
         .bal_en  (bal_en),
         .load    (word_stb),
         .shift   (shift),
         .grp     (word_w[l*GROUP_W +: GROUP_W]),
         .ser     (lane_out[l]),
         .run_sum (rs_l)
      );
      assign run_sums[l*DSUM_W +: DSUM_W] = rs_l;
   end

   dcb_clk_lane #(
      .GROUP_W (GROUP_W)
   ) u_clk (
      .clk    (clk),
      .rst    (rst),
      .bal_en (bal_en),
      .load   (word_stb),
      .shift  (shift),
      .ser    (clk_lane_out)
   );

endmodule

// File: rtl/dcb_encoder_chk.sv
module dcb_encoder_chk #(
   parameter int LANES   = 3,
   parameter int GROUP_W = 7,
   parameter int DSUM_W  = 5
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    bal_en,
   input logic                    word_stb,
   input logic                    bit_en,
   input logic [LANES-1:0]        lane_out,
   input logic                    clk_lane_out,
   input logic [LANES*DSUM_W-1:0] run_sums
);
   logic rst_q;
   always_ff @(posedge clk) rst_q <= rst;

   always @(posedge clk)
      if (rst_q === 1'b1)
         AST_RESET_CLEAR: assert (lane_out == '0 && !clk_lane_out && run_sums == '0); // R9

   for (genvar l = 0; l < LANES; l++) begin : g_bound
      logic signed [DSUM_W-1:0] rs_v;
      assign rs_v = run_sums[l*DSUM_W +: DSUM_W];
      AST_SUM_BOUND: assert property (@(posedge clk) disable iff (rst)
         (rs_v <= DSUM_W'(GROUP_W)) && (rs_v >= -DSUM_W'(GROUP_W))); // R5
   end

   AST_SUM_ONLY_ON_BAL_LOAD: assert property (@(posedge clk) disable iff (rst)
      !(word_stb && bal_en) |=> $stable(run_sums)); // R4

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!word_stb && !bit_en) |=> ($stable(lane_out) && $stable(clk_lane_out))); // R2

   AST_FLAGS_COMPL: assert property (@(posedge clk) disable iff (rst)
      (word_stb && bal_en) ##1 (bit_en && !word_stb) |=> (lane_out == ~$past(lane_out))); // R3

   AST_CLK_STARTS_HIGH: assert property (@(posedge clk) disable iff (rst)
      word_stb |=> clk_lane_out); // R6

endmodule

bind dcb_lane_encoder dcb_encoder_chk #(
   .LANES   (LANES),
   .GROUP_W (GROUP_W),
   .DSUM_W  (DSUM_W)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .bal_en       (bal_en),
   .word_stb     (word_stb),
   .bit_en       (bit_en),
   .lane_out     (lane_out),
   .clk_lane_out (clk_lane_out),
   .run_sums     (run_sums)
);

// File: tb/sim_dcb_lane_encoder.sv
module sim_dcb_lane_encoder;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bal_en = 1'b0;
   logic        word_stb = 1'b0;
   logic [20:0] word_in = '0;
   logic        bit_en = 1'b0;
   logic [2:0]  lane_out;
   logic        clk_lane_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // reference state
   int  rs_m [3];
   bit  ph_long_m;

   always #5 clk = ~clk;

   dcb_lane_encoder u0 (
      .clk          (clk),
      .rst          (rst),
      .bal_en       (bal_en),
      .word_stb     (word_stb),
      .word_in      (word_in),
      .bit_en       (bit_en),
      .lane_out     (lane_out),
      .clk_lane_out (clk_lane_out)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // R4 reference: complement when the sum is nonzero and has the disparity's sign
   function automatic logic [8:0] enc_group(input logic [6:0] g, inout int rs);
      int  d;
      bit  inv;
      d   = 2 * $countones(g) - 7;
      inv = (rs != 0) && ((d > 0) == (rs > 0));
      rs  = rs + (inv ? -d : d);
      return {inv, !inv, (inv ? ~g : g)};
   endfunction

   task automatic send_word(input logic [20:0] w, input bit bal, input bit en_on_load);
      logic [8:0] sym [3];
      logic [6:0] grp [3];
      int n, hi, k;
      bit en;
      for (int l = 0; l < 3; l++) begin
         grp[l] = w[7*l +: 7];             // R1 lane mapping
         if (bal) sym[l] = enc_group(grp[l], rs_m[l]);
         else     sym[l] = '0;
      end
      n  = bal ? 9 : 7;
      hi = bal ? (ph_long_m ? 5 : 4) : 4;
      if (bal) ph_long_m = !ph_long_m;    // R7: raw words keep the phase

      @(negedge clk);
      word_in = w; bal_en = bal; word_stb = 1'b1;
      bit_en  = en_on_load;                // R10: the load must win
      @(negedge clk);
      word_stb = 1'b0;
      k = 0;
      while (1) begin
         for (int l = 0; l < 3; l++) begin
            if (bal) chk((k < 2) ? "R3" : "R4", lane_out[l], sym[l][8-k]); // R5 sums stay bounded
            else     chk("R7", lane_out[l], grp[l][6-k]);
         end
         chk(bal ? "R6" : "R8", clk_lane_out, (k < hi));
         if (en_on_load && k == 0) chk("R10", lane_out[0], bal ? sym[0][8] : grp[0][6]);
         if (k == n - 1) break;
         en = ($urandom_range(0, 3) != 0); // R2 stalls hold the output
         bit_en = en;
         @(negedge clk);
         if (en) k++;
      end
      bit_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      for (int l = 0; l < 3; l++) rs_m[l] = 0;
      ph_long_m = 0;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9", lane_out[0], 1'b0);
      chk("R9", lane_out[1], 1'b0);
      chk("R9", lane_out[2], 1'b0);
      chk("R9", clk_lane_out, 1'b0);
      rst = 1'b0;

      // directed: all zeros repeatedly (inversion alternates), all ones
      repeat (4) send_word(21'h000000, 1'b1, 1'b0);
      repeat (2) send_word(21'h1FFFFF, 1'b1, 1'b0);
      // lane mapping pattern, distinct per lane (R1)
      send_word({7'h7F, 7'h01, 7'h0F}, 1'b1, 1'b0);
      // raw words in between keep sums and phase (R7, R8)
      send_word({7'h55, 7'h2A, 7'h70}, 1'b0, 1'b0);
      send_word(21'h1FFFFF, 1'b0, 1'b0);
      send_word(21'h000003, 1'b1, 1'b0);
      // load together with bit enable (R10)
      send_word(21'h0AB123, 1'b1, 1'b1);
      send_word(21'h154321, 1'b0, 1'b1);

      // reset mid-run, then start again (R9)
      @(negedge clk); rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R9", lane_out[0] | lane_out[1] | lane_out[2], 1'b0);
      chk("R9", clk_lane_out, 1'b0);
      rst = 1'b0;
      for (int l = 0; l < 3; l++) rs_m[l] = 0;
      ph_long_m = 0;

      // seeded random words and modes
      for (int i = 0; i < 80; i++)
         send_word(21'($urandom), ($urandom_range(0, 3) != 0), ($urandom_range(0, 4) == 0));

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule